// File: doc/BRIEF.md
# DDR Mode Register and Burst Column Sequencer

This block keeps the base mode register of a DDR SDRAM style device and uses it to run read bursts. A load-mode command writes the register from a bank-select pair and an address word. Only the base register is written; an extended-register load is dropped. The register fields are decoded into burst length, burst ordering, read latency and operating mode. Any reserved field raises a configuration flag.

A read command is a valid/ready transfer that carries a starting column. When the read is accepted, the block captures the current length, ordering and latency with it. Once the latency has passed, it streams the column of every beat in the burst. The DDR bus moves two beats per clock, so each cycle of the data-valid strobe carries an even beat and the following odd beat.

Reads are queued in order. Back-pressure (`rd_ready` low) occurs only when the pending queue is full. A read offered while `rd_ready` is low is not taken, and the source must hold it. The data-valid stream has no ready: its timing is set by the latency, and the consumer must take every beat.

Top module: `burst_colseq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dv` and `rd_err` are 0, `rd_ready` is 1, and the register holds all zeros, so that `cfg_reserved`=1 and `cfg_burst_len`=0.
- R2: The register is written at a clock edge where `lmr_en`=1 and `lmr_bank`=2'b00, and the decoded outputs show the new value in the next cycle. A load with any other bank value leaves every `cfg_*` output unchanged.
- R3: Word bits [2:0] set the burst length: 3'b001→2, 3'b010→4, 3'b011→8. Every other code is reserved and gives `cfg_burst_len`=0 and `cfg_reserved`=1.
- R4: Word bit 3 sets the ordering: 0 is sequential, 1 is interleaved. `cfg_interleave` shows this bit.
- R5: Word bits [6:4] set the read latency: 3'b010→2 clocks, 3'b011→3 clocks. Every other code is reserved and gives `cfg_cas_lat`=0 and `cfg_reserved`=1.
- R6: Word bits [ADDR_W-1:7] set the operating mode. All zeros is normal. A value of exactly 2 (only bit 8 set) is normal with DLL reset and sets `cfg_dll_reset`=1. Any other value is reserved.
- R7: A read accepted while `cfg_reserved`=1 raises `rd_err` for the one cycle after its edge. It starts no burst and takes no queue slot.
- R8: A read accepted at edge n with latency L and length BL drives `dv` high in the cycles after edges n+L through n+L+BL/2-1, provided no earlier burst is still running.
- R9: In sequential order, beat i has low log2(BL) column bits equal to (start+i) mod BL, and the upper bits of `rd_col` are unchanged. In the k-th `dv` cycle, `dv_col0` is beat 2k and `dv_col1` is beat 2k+1. A 4-beat burst from offset 1 gives 1-2-3-0.
- R10: In interleaved order, the low log2(BL) bits of beat i are (start XOR i), so a 4-beat burst from offset 1 gives 1-0-3-2. Offset 0 gives 0-1-2-3 in both orders.
- R11: Bursts run in acceptance order. Each burst starts at the later of its own edge n+L and the cycle after the previous burst ends. `rd_ready` is 0 while DEPTH accepted reads are waiting to start, and a read offered then is ignored.
- R12: Each burst uses the length, ordering and latency in force at the edge where its read was accepted. A later load does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lmr_en | input | 1 | Load-mode command |
| lmr_bank | input | 2 | Bank select for the load; 2'b00 selects the base register |
| lmr_addr | input | ADDR_W | Register word |
| rd_valid | input | 1 | Read command offered |
| rd_ready | output | 1 | Read command can be accepted |
| rd_col | input | COL_W | Starting column of the read |
| rd_err | output | 1 | A read was refused because of a reserved setting |
| dv | output | 1 | Data-valid strobe, one cycle per beat pair |
| dv_col0 | output | COL_W | Column of the even beat of this cycle |
| dv_col1 | output | COL_W | Column of the odd beat of this cycle |
| cfg_burst_len | output | 4 | Decoded burst length (2, 4, 8, or 0 if reserved) |
| cfg_interleave | output | 1 | Interleaved ordering selected |
| cfg_cas_lat | output | 2 | Decoded read latency (2, 3, or 0 if reserved) |
| cfg_dll_reset | output | 1 | Operating mode is normal with DLL reset |
| cfg_reserved | output | 1 | A reserved setting is loaded |

## Verification
A corrupted register or decode shows on the `cfg_*` outputs in the cycle after the load. It also shows in the next read, as an `rd_err` that should not be there or a burst of the wrong length. A countdown stuck in a queue slot moves the first `dv` cycle away from edge n+L, and every later burst in the queue slips with it. A wrong beat index or offset mask gives a wrong column pair in the same `dv` cycle. A lost pointer or a bad occupancy count shows as `rd_ready` disagreeing with the number of pending reads, or as bursts that come out of order or go missing.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    OPM_NORMAL  = 2'd0,
    OPM_DLL_RST = 2'd1,
    OPM_BAD     = 2'd2
  } opmode_e;

  // low column bits of beat idx; lg = log2(burst length), 1..3
  function automatic logic [2:0] beat_offset(input logic [2:0] start_lo,
                                             input logic [2:0] idx,
                                             input logic [1:0] lg,
                                             input logic       ilv);
    logic [2:0] mask;
    mask = 3'((4'd1 << lg) - 4'd1);
    if (ilv) beat_offset = (start_lo ^ idx) & mask;
    else     beat_offset = (start_lo + idx) & mask;
  endfunction

endpackage

// File: rtl/burst_modereg.sv
module burst_modereg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [1:0]        bank,
  input  logic [ADDR_W-1:0] word,
  output logic [1:0]        lg,
  output logic              ilv,
  output logic [1:0]        cas,
  output opmode_e           mode,
  output logic              bad
);
  localparam int MODE_W = ADDR_W - 7;

  logic [ADDR_W-1:0] mr_q;
  logic [MODE_W-1:0] mode_f;
  logic              bl_ok, cl_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                           mr_q <= '0;
    else if (load_en && bank == 2'b00)    mr_q <= word;
  end

  assign mode_f = mr_q[ADDR_W-1:7];
  assign ilv    = mr_q[3];

  always_comb begin
    bl_ok = 1'b1;
    case (mr_q[2:0])
      3'b001:  lg = 2'd1;
      3'b010:  lg = 2'd2;
      3'b011:  lg = 2'd3;
      default: begin lg = 2'd0; bl_ok = 1'b0; end
    endcase
    cl_ok = 1'b1;
    case (mr_q[6:4])
      3'b010:  cas = 2'd2;
      3'b011:  cas = 2'd3;
      default: begin cas = 2'd0; cl_ok = 1'b0; end
    endcase
    if (mode_f == '0)                  mode = OPM_NORMAL;
    else if (mode_f == MODE_W'(2))     mode = OPM_DLL_RST;
    else                               mode = OPM_BAD;
    bad = !bl_ok || !cl_ok || (mode == OPM_BAD);
  end

endmodule

// File: rtl/burst_rdq.sv
module burst_rdq #(
  parameter int COL_W = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [COL_W-1:0] push_col,
  input  logic [1:0]       push_lg,
  input  logic             push_ilv,
  input  logic [1:0]       push_wait,
  input  logic             pop,
  output logic             full,
  output logic             head_due,
  output logic [COL_W-1:0] head_col,
  output logic [1:0]       head_lg,
  output logic             head_ilv
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0]    wptr_q, rptr_q;
  logic [PW:0]      cnt_q;
  logic [COL_W-1:0] col_v  [DEPTH];
  logic [1:0]       lg_v   [DEPTH];
  logic             ilv_v  [DEPTH];
  logic [1:0]       wait_v [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [COL_W-1:0] col_r;
    logic [1:0]       lg_r;
    logic             ilv_r;
    logic [1:0]       wait_r;
    logic             wr;
    assign wr = push && (wptr_q == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)              wait_r <= 2'd0;
      else if (wr)             wait_r <= push_wait;
      else if (wait_r != 2'd0) wait_r <= wait_r - 2'd1;
    end

    always_ff @(posedge clk) begin
      if (wr) begin
        col_r <= push_col;
        lg_r  <= push_lg;
        ilv_r <= push_ilv;
      end
    end

    assign col_v[g]  = col_r;
    assign lg_v[g]   = lg_r;
    assign ilv_v[g]  = ilv_r;
    assign wait_v[g] = wait_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign full     = (cnt_q == (PW+1)'(DEPTH));
  assign head_due = (cnt_q != '0) && (wait_v[rptr_q] == 2'd0);
  assign head_col = col_v[rptr_q];
  assign head_lg  = lg_v[rptr_q];
  assign head_ilv = ilv_v[rptr_q];

endmodule

// File: rtl/burst_engine.sv
module burst_engine
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] ld_col,
  input  logic [1:0]       ld_lg,
  input  logic             ld_ilv,
  output logic             can_load,
  output logic             dv,
  output logic [COL_W-1:0] col0,
  output logic [COL_W-1:0] col1
);
  logic             active_q, ilv_q;
  logic [1:0]       k_q, lg_q, last_k;
  logic [COL_W-1:0] start_q, base;
  logic [2:0]       mask;
  logic             at_last;

  always_comb begin
    case (lg_q)
      2'd1:    last_k = 2'd0;
      2'd2:    last_k = 2'd1;
      default: last_k = 2'd3;
    endcase
  end

  assign at_last  = active_q && (k_q == last_k);
  assign can_load = !active_q || at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      k_q      <= 2'd0;
      lg_q     <= 2'd1;
      ilv_q    <= 1'b0;
      start_q  <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      k_q      <= 2'd0;
      lg_q     <= ld_lg;
      ilv_q    <= ld_ilv;
      start_q  <= ld_col;
    end else if (at_last) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      k_q <= k_q + 2'd1;
    end
  end

  assign mask = 3'((4'd1 << lg_q) - 4'd1);
  assign base = {start_q[COL_W-1:3], start_q[2:0] & ~mask};
  assign dv   = active_q;
  assign col0 = base | COL_W'(beat_offset(start_q[2:0], {k_q, 1'b0}, lg_q, ilv_q));
  assign col1 = base | COL_W'(beat_offset(start_q[2:0], {k_q, 1'b1}, lg_q, ilv_q));

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int COL_W  = 10,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lmr_en,
  input  logic [1:0]        lmr_bank,
  input  logic [ADDR_W-1:0] lmr_addr,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [COL_W-1:0]  rd_col,
  output logic              rd_err,
  output logic              dv,
  output logic [COL_W-1:0]  dv_col0,
  output logic [COL_W-1:0]  dv_col1,
  output logic [3:0]        cfg_burst_len,
  output logic              cfg_interleave,
  output logic [1:0]        cfg_cas_lat,
  output logic              cfg_dll_reset,
  output logic              cfg_reserved
);
  logic [1:0]       m_lg, m_cas;
  logic             m_ilv, m_bad;
  opmode_e          m_mode;
  logic             q_full, q_due, q_ilv, eng_free;
  logic [COL_W-1:0] q_col;
  logic [1:0]       q_lg;
  logic             accept, push, pop, err_q;

  burst_modereg #(.ADDR_W(ADDR_W)) u_mr (
    .clk(clk), .rst_n(rst_n), .load_en(lmr_en), .bank(lmr_bank), .word(lmr_addr),
    .lg(m_lg), .ilv(m_ilv), .cas(m_cas), .mode(m_mode), .bad(m_bad)
  );

  assign rd_ready = !q_full;
  assign accept   = rd_valid && rd_ready;
  assign push     = accept && !m_bad;
  assign pop      = q_due && eng_free;

  burst_rdq #(.COL_W(COL_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_col(rd_col), .push_lg(m_lg),
    .push_ilv(m_ilv), .push_wait(m_cas - 2'd1), .pop(pop), .full(q_full),
    .head_due(q_due), .head_col(q_col), .head_lg(q_lg), .head_ilv(q_ilv)
  );

  burst_engine #(.COL_W(COL_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(pop), .ld_col(q_col), .ld_lg(q_lg),
    .ld_ilv(q_ilv), .can_load(eng_free), .dv(dv), .col0(dv_col0), .col1(dv_col1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && m_bad;
  end

  assign rd_err         = err_q;
  assign cfg_burst_len  = (m_lg == 2'd0) ? 4'd0 : 4'(4'd1 << m_lg);
  assign cfg_interleave = m_ilv;
  assign cfg_cas_lat    = m_cas;
  assign cfg_dll_reset  = (m_mode == OPM_DLL_RST);
  assign cfg_reserved   = m_bad;

endmodule

// File: rtl/burst_colseq_chk.sv
module burst_colseq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lmr_en,
  input logic [1:0]       lmr_bank,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             rd_err,
  input logic             dv,
  input logic [COL_W-1:0] dv_col0,
  input logic [COL_W-1:0] dv_col1,
  input logic [3:0]       cfg_burst_len,
  input logic             cfg_interleave,
  input logic [1:0]       cfg_cas_lat,
  input logic             cfg_dll_reset,
  input logic             cfg_reserved
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lmr_en || lmr_bank != 2'b00) |=>
      $stable({cfg_burst_len, cfg_interleave, cfg_cas_lat, cfg_dll_reset, cfg_reserved})); // R2

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reserved |-> (cfg_burst_len == 4'd2 || cfg_burst_len == 4'd4 || cfg_burst_len == 4'd8)); // R3

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reserved |-> (cfg_cas_lat == 2'd2 || cfg_cas_lat == 2'd3)); // R5

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(rd_valid && rd_ready && cfg_reserved)); // R7

  AST_ERR_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_ready); // R7

  AST_PAIR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    dv |-> ((dv_col0 >> 3) == (dv_col1 >> 3))); // R9

  AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    dv |-> (dv_col0[0] != dv_col1[0])); // R10

endmodule

bind burst_colseq burst_colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lmr_en(lmr_en), .lmr_bank(lmr_bank),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_err(rd_err), .dv(dv),
  .dv_col0(dv_col0), .dv_col1(dv_col1), .cfg_burst_len(cfg_burst_len),
  .cfg_interleave(cfg_interleave), .cfg_cas_lat(cfg_cas_lat),
  .cfg_dll_reset(cfg_dll_reset), .cfg_reserved(cfg_reserved)
);

// File: tb/burst_colseq_bench.sv
module burst_colseq_bench;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 14;
  localparam int COL_W  = 10;
  localparam int DEPTH  = 4;
  localparam int RING   = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lmr_en = 1'b0, rd_valid = 1'b0;
  logic [1:0] lmr_bank = '0;
  logic [ADDR_W-1:0] lmr_addr = '0;
  logic [COL_W-1:0] rd_col = '0;
  logic rd_ready, rd_err, dv, cfg_interleave, cfg_dll_reset, cfg_reserved;
  logic [COL_W-1:0] dv_col0, dv_col1;
  logic [3:0] cfg_burst_len;
  logic [1:0] cfg_cas_lat;

  burst_colseq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DEPTH(DEPTH)) u_burst_colseq (
    .clk(clk), .rst_n(rst_n), .lmr_en(lmr_en), .lmr_bank(lmr_bank), .lmr_addr(lmr_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_col(rd_col), .rd_err(rd_err),
    .dv(dv), .dv_col0(dv_col0), .dv_col1(dv_col1), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cfg_cas_lat(cfg_cas_lat),
    .cfg_dll_reset(cfg_dll_reset), .cfg_reserved(cfg_reserved)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, next_free = 0, st_wp = 0;
  logic [ADDR_W-1:0] m_word = '0;
  bit exp_dv [RING];
  bit exp_err [RING];
  int exp_c0 [RING];
  int exp_c1 [RING];
  string exp_tag [RING];
  int starts [16];
  bit snap_tag = 1'b0;

  function automatic int f_bl(logic [ADDR_W-1:0] w);
    case (w[2:0]) 3'b001: return 2; 3'b010: return 4; 3'b011: return 8; default: return 0; endcase
  endfunction
  function automatic int f_cl(logic [ADDR_W-1:0] w);
    case (w[6:4]) 3'b010: return 2; 3'b011: return 3; default: return 0; endcase
  endfunction
  function automatic int f_mode(logic [ADDR_W-1:0] w);
    int m = int'(w >> 7);
    return (m == 0) ? 0 : (m == 2) ? 1 : 2;
  endfunction
  function automatic bit f_res(logic [ADDR_W-1:0] w);
    return f_bl(w) == 0 || f_cl(w) == 0 || f_mode(w) == 2;
  endfunction
  function automatic int col_of(int s, int bl, bit ilv, int i);
    int lo = s % bl;
    int o = ilv ? (lo ^ i) : ((lo + i) % bl);
    return s - lo + o;
  endfunction
  function automatic logic [ADDR_W-1:0] mkword(int blc, int bt, int clc, int mode);
    logic [ADDR_W-1:0] w = '0;
    w[2:0] = 3'(blc); w[3] = 1'(bt); w[6:4] = 3'(clc); w[ADDR_W-1:7] = (ADDR_W-7)'(mode);
    return w;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic check_cycle();
    int idx = cyc % RING;
    int pend = 0;
    chk(dv == exp_dv[idx], "R8", "dv", int'(dv), int'(exp_dv[idx]));
    if (dv && exp_dv[idx]) begin
      chk(int'(dv_col0) == exp_c0[idx], exp_tag[idx], "dv_col0", int'(dv_col0), exp_c0[idx]);
      chk(int'(dv_col1) == exp_c1[idx], exp_tag[idx], "dv_col1", int'(dv_col1), exp_c1[idx]);
    end
    chk(rd_err == exp_err[idx], "R7", "rd_err", int'(rd_err), int'(exp_err[idx]));
    exp_dv[idx] = 1'b0; exp_err[idx] = 1'b0;
    chk(int'(cfg_burst_len) == f_bl(m_word), "R3", "cfg_burst_len", int'(cfg_burst_len), f_bl(m_word));
    chk(cfg_interleave == m_word[3], "R4", "cfg_interleave", int'(cfg_interleave), int'(m_word[3]));
    chk(int'(cfg_cas_lat) == f_cl(m_word), "R5", "cfg_cas_lat", int'(cfg_cas_lat), f_cl(m_word));
    chk(cfg_dll_reset == (f_mode(m_word) == 1), "R6", "cfg_dll_reset", int'(cfg_dll_reset), int'(f_mode(m_word) == 1));
    chk(cfg_reserved == f_res(m_word), "R6", "cfg_reserved", int'(cfg_reserved), int'(f_res(m_word)));
    for (int j = 0; j < 16; j++) if (starts[j] > cyc) pend++;
    chk(rd_ready == (pend < DEPTH), "R11", "rd_ready", int'(rd_ready), int'(pend < DEPTH));
  endtask

  task automatic step(bit lmr, logic [1:0] bank, logic [ADDR_W-1:0] word, bit rv, logic [COL_W-1:0] col);
    lmr_en = lmr; lmr_bank = bank; lmr_addr = word; rd_valid = rv; rd_col = col;
    if (rv && rd_ready) begin
      int e = cyc + 1;
      if (f_res(m_word)) exp_err[e % RING] = 1'b1;
      else begin
        int bl = f_bl(m_word);
        bit ilv = m_word[3];
        int s = e + f_cl(m_word);
        if (next_free > s) s = next_free;
        for (int k = 0; k < bl / 2; k++) begin
          exp_dv[(s + k) % RING]  = 1'b1;
          exp_c0[(s + k) % RING]  = col_of(int'(col), bl, ilv, 2 * k);
          exp_c1[(s + k) % RING]  = col_of(int'(col), bl, ilv, 2 * k + 1);
          exp_tag[(s + k) % RING] = snap_tag ? "R12" : (ilv ? "R10" : "R9");
        end
        next_free = s + bl / 2;
        starts[st_wp] = s;
        st_wp = (st_wp + 1) % 16;
      end
    end
    if (lmr && bank == 2'b00) m_word = word;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check_cycle();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, '0, 1'b0, '0);
  endtask

  task automatic load(logic [ADDR_W-1:0] w);
    step(1'b1, 2'b00, w, 1'b0, '0);
  endtask

  task automatic rd(logic [COL_W-1:0] c);
    step(1'b0, 2'b00, '0, 1'b1, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int j = 0; j < 16; j++) starts[j] = -1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dv == 1'b0, "R1", "dv in reset", int'(dv), 0);
    chk(rd_err == 1'b0, "R1", "rd_err in reset", int'(rd_err), 0);
    chk(rd_ready == 1'b1, "R1", "rd_ready in reset", int'(rd_ready), 1);
    chk(cfg_reserved == 1'b1, "R1", "cfg_reserved in reset", int'(cfg_reserved), 1);
    chk(cfg_burst_len == 4'd0, "R1", "cfg_burst_len in reset", int'(cfg_burst_len), 0);
    rst_n = 1'b1;
    cyc = 0;
    // R7: read before any load is refused
    rd(10'h055);
    idle(2);
    // R2: extended-register load ignored
    step(1'b1, 2'b01, mkword(2, 0, 2, 0), 1'b0, '0);
    idle(1);
    chk(cfg_reserved == 1'b1, "R2", "cfg_reserved after bank 01 load", int'(cfg_reserved), 1);
    chk(cfg_burst_len == 4'd0, "R2", "cfg_burst_len after bank 01 load", int'(cfg_burst_len), 0);
    // R9: BL4 sequential latency 2, offset 1 -> 1-2-3-0
    load(mkword(2, 0, 2, 0));
    rd(10'h101);
    idle(6);
    // R10: BL4 interleaved latency 3, offset 1 -> 1-0-3-2, offset 0 -> 0-1-2-3
    load(mkword(2, 1, 3, 0));
    rd(10'h101);
    idle(4);
    rd(10'h2A0);
    idle(6);
    // R11: BL8 back to back fills the queue
    load(mkword(3, 0, 2, 0));
    for (int i = 0; i < 7; i++) rd(COL_W'($urandom));
    idle(30);
    // R8: BL8 interleaved latency 3, spaced for a gapless stream
    load(mkword(3, 1, 3, 0));
    for (int i = 0; i < 4; i++) begin rd(COL_W'($urandom)); idle(3); end
    idle(8);
    // R6: DLL reset mode, then reserved mode values
    load(mkword(1, 0, 2, 2));
    rd(10'h3FF);
    idle(4);
    load(mkword(1, 0, 2, 3));
    rd(10'h001);
    load(mkword(7, 0, 2, 0));
    rd(10'h002);
    load(mkword(2, 0, 6, 0));
    rd(10'h003);
    idle(3);
    // R12: burst keeps its settings across a later load
    load(mkword(3, 0, 3, 0));
    snap_tag = 1'b1;
    rd(10'h1F5);
    snap_tag = 1'b0;
    load(mkword(1, 1, 2, 0));
    rd(10'h0C3);
    idle(16);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      if (r < 5) begin
        int blc = ($urandom % 8 < 6) ? int'(1 + $urandom % 3) : int'($urandom % 8);
        int clc = ($urandom % 8 < 6) ? int'(2 + $urandom % 2) : int'($urandom % 8);
        int mr  = int'($urandom % 10);
        int md  = (mr < 8) ? 0 : (mr == 8) ? 2 : int'($urandom % 128);
        logic [1:0] bk = ($urandom % 5 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
        step(1'b1, bk, mkword(blc, int'($urandom % 2), clc, md), 1'b0, '0);
      end else if (r < 45) begin
        rd(COL_W'($urandom));
      end else begin
        idle(1);
      end
    end
    idle(40);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule